// File: doc/BRIEF.md
# In-Order Non-Blocking Load Buffer

This block sits between load issue and the data cache. It lets the pipeline keep issuing loads after a cache miss, and it still hands load results back strictly in the order the loads were issued. Each issued load carries a tag and a hit/miss flag, plus the cache data when it hit. A load that misses takes a slot in a circular queue and waits there until the memory side returns a fill with the same tag. Fills may come back in any order.

A hit that arrives while the queue is empty skips the queue. Its result appears on the return port one cycle later. A hit that arrives while any older load is still queued is stored behind those loads together with its data, so it cannot overtake them. Only the oldest queued entry can leave the queue, and it leaves only once its data is present. At most one result is returned per cycle. When every slot is occupied, a full flag rises and any issue attempt made while it is high is dropped.

Top module: `lb_inorder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ret_valid` and `full` are 0.
- R2: If a hit is issued while the queue holds no load, `ret_valid` is 1 on the following cycle, with the issued tag and the issued cache data.
- R3: A miss never blocks issue. Loads issued on consecutive cycles are all accepted while fewer than DEPTH loads are outstanding.
- R4: Results leave in issue order. A hit issued behind an outstanding miss is returned only after that miss has been returned.
- R5: A hit that enters the queue returns the cache data presented with it at issue time.
- R6: A fill updates only the waiting miss whose tag matches it, and it returns that fill's data. Fills may arrive in any order. A fill whose tag matches no waiting miss changes nothing.
- R7: An entry leaves the queue only when it is the oldest and its data is present. A fill that completes the oldest entry in cycle t makes that entry appear on the return port in cycle t+2. Completed entries queued behind it follow one per cycle.
- R8: `full` is 1 exactly when DEPTH loads are queued. An issue attempt while `full` is 1 is dropped and never returned. `full` falls in the cycle after an entry leaves the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A load is issued this cycle |
| iss_tag | input | TAG_W | Tag of the issued load |
| iss_hit | input | 1 | 1 = cache hit, 0 = miss |
| iss_data | input | DATA_W | Cache data when the load hit |
| fill_valid | input | 1 | Miss data is returned this cycle |
| fill_tag | input | TAG_W | Tag of the returned miss |
| fill_data | input | DATA_W | Returned miss data |
| ret_valid | output | 1 | A load result is presented |
| ret_tag | output | TAG_W | Tag of the presented result |
| ret_data | output | DATA_W | Data of the presented result |
| full | output | 1 | Every queue slot is occupied |

## Verification
The hardest situation to reach is a queue filled with a mix of waiting misses and completed hits whose fills then arrive in a scrambled order. Only that combination shows whether a later completed entry ever gets past an older waiting one. The bench sweeps every hit/miss pattern of four back-to-back loads against four different fill orders. A directed run fills the queue with misses, offers a fifth load while `full` is high, sends a fill with a tag that matches nothing, and completes the second entry before the first.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int LB_DEPTH  = 4;
  localparam int LB_TAG_W  = 4;
  localparam int LB_DATA_W = 16;

  // source selected for the return register
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_HEAD   = 2'd2
  } ret_src_e;
endpackage

// File: rtl/lb_ptrs.sv
module lb_ptrs #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_nxt, tail_nxt;
  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    head_nxt  = head;
    tail_nxt  = tail;
    count_nxt = count;
    if (enq) tail_nxt = (tail == LAST) ? '0 : tail + 1'b1;
    if (pop) head_nxt = (head == LAST) ? '0 : head + 1'b1;
    case ({enq, pop})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (enq || pop) begin
      head  <= head_nxt;
      tail  <= tail_nxt;
      count <= count_nxt;
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r4_empty_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (head == tail));
endmodule

// File: rtl/lb_slots.sv
module lb_slots #(
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq,
  input  logic [PTR_W-1:0]  tail,
  input  logic              iss_hit,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [DATA_W-1:0] iss_data,
  input  logic              pop,
  input  logic [PTR_W-1:0]  head,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic              head_rdy,
  output logic [TAG_W-1:0]  head_tag,
  output logic [DATA_W-1:0] head_data
);
  logic [DEPTH-1:0]  occ, rdy;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic load, drop, match;
    logic occ_nxt, rdy_nxt;

    assign load  = enq && (tail == PTR_W'(i));
    assign drop  = pop && (head == PTR_W'(i));
    assign match = fill_valid && occ[i] && !rdy[i] && (tag_q[i] == fill_tag);

    always_comb begin
      occ_nxt = occ[i];
      rdy_nxt = rdy[i];
      if (load) begin
        occ_nxt = 1'b1;
        rdy_nxt = iss_hit;
      end else if (drop) begin
        occ_nxt = 1'b0;
        rdy_nxt = 1'b0;
      end else if (match) begin
        rdy_nxt = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ[i] <= 1'b0;
        rdy[i] <= 1'b0;
      end else if (load || drop || match) begin
        occ[i] <= occ_nxt;
        rdy[i] <= rdy_nxt;
      end
    end

    always_ff @(posedge clk) begin
      if (load) begin
        tag_q[i]  <= iss_tag;
        data_q[i] <= iss_data;
      end else if (match) begin
        data_q[i] <= fill_data;
      end
    end

    // R6: a completed entry is untouched by later fills until it leaves
    a_r6_ready_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[i] && rdy[i] && !drop) |=> (rdy[i] && $stable(data_q[i])));
  end

  assign head_rdy  = occ[head] && rdy[head];
  assign head_tag  = tag_q[head];
  assign head_data = data_q[head];

  a_r7_pop_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ[head] && rdy[head]));
endmodule

// File: rtl/lb_out.sv
module lb_out
  import lb_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byp,
  input  logic [TAG_W-1:0]  byp_tag,
  input  logic [DATA_W-1:0] byp_data,
  input  logic              pop,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic [DATA_W-1:0] head_data,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DATA_W-1:0] ret_data
);
  ret_src_e          src;
  logic [TAG_W-1:0]  tag_nxt;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    src      = SRC_NONE;
    tag_nxt  = ret_tag;
    data_nxt = ret_data;
    if (pop) begin
      src      = SRC_HEAD;
      tag_nxt  = head_tag;
      data_nxt = head_data;
    end else if (byp) begin
      src      = SRC_BYPASS;
      tag_nxt  = byp_tag;
      data_nxt = byp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_valid <= 1'b0;
    else        ret_valid <= (src != SRC_NONE);
  end

  always_ff @(posedge clk) begin
    if (src != SRC_NONE) begin
      ret_tag  <= tag_nxt;
      ret_data <= data_nxt;
    end
  end

  a_r7_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(byp && pop));
endmodule

// File: rtl/lb_inorder.sv
module lb_inorder
  import lb_pkg::*;
#(
  parameter int DEPTH  = LB_DEPTH,
  parameter int TAG_W  = LB_TAG_W,
  parameter int DATA_W = LB_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              iss_hit,
  input  logic [DATA_W-1:0] iss_data,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DATA_W-1:0] ret_data,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              empty, enq, byp, pop, head_rdy;
  logic [TAG_W-1:0]  head_tag;
  logic [DATA_W-1:0] head_data;

  // a hit skips the queue only when nothing older is waiting
  assign byp = iss_valid && iss_hit && empty;
  assign enq = iss_valid && !full && !byp;
  assign pop = head_rdy;

  lb_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .enq(enq), .pop(pop),
    .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
  );

  lb_slots #(.DEPTH(DEPTH), .PTR_W(PTR_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .enq(enq), .tail(tail), .iss_hit(iss_hit),
    .iss_tag(iss_tag), .iss_data(iss_data), .pop(pop), .head(head),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
    .head_rdy(head_rdy), .head_tag(head_tag), .head_data(head_data)
  );

  lb_out #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .byp(byp), .byp_tag(iss_tag), .byp_data(iss_data),
    .pop(pop), .head_tag(head_tag), .head_data(head_data),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data)
  );

  a_r2_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_hit && count == '0) |=>
      (ret_valid && ret_tag == $past(iss_tag) && ret_data == $past(iss_data)));
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  a_r8_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (full && iss_valid && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: tb/sim_lb_inorder.sv
module sim_lb_inorder;
  localparam int DEPTH  = 4;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              iss_valid = 1'b0, iss_hit = 1'b0, fill_valid = 1'b0;
  logic [TAG_W-1:0]  iss_tag = '0, fill_tag = '0;
  logic [DATA_W-1:0] iss_data = '0, fill_data = '0;
  logic              ret_valid, full;
  logic [TAG_W-1:0]  ret_tag;
  logic [DATA_W-1:0] ret_data;

  int total = 0, bad = 0, nret = 0, cyc = 0, ntag = 0;
  int exp_wr = 0, exp_rd = 0;
  bit done = 1'b0;
  logic [TAG_W-1:0]  exp_tag  [1024];
  logic [DATA_W-1:0] exp_data [1024];

  always #4 clk = ~clk;

  lb_inorder #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tag(iss_tag),
    .iss_hit(iss_hit), .iss_data(iss_data), .fill_valid(fill_valid),
    .fill_tag(fill_tag), .fill_data(fill_data), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .ret_data(ret_data), .full(full)
  );

  function automatic logic [DATA_W-1:0] hit_val(input int t);
    return DATA_W'(16'hC000 + t * 131);
  endfunction
  function automatic logic [DATA_W-1:0] fill_val(input int t);
    return DATA_W'(16'h3000 + t * 977);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // return monitor: every result must be the oldest accepted load (R4, R5, R6)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && ret_valid === 1'b1 && !done) begin
      nret++;
      if (exp_rd == exp_wr) begin
        check(1'b0, "R4 unexpected return tag", int'(ret_tag), -1);
      end else begin
        check(ret_tag == exp_tag[exp_rd % 1024], "R4 return order tag",
              int'(ret_tag), int'(exp_tag[exp_rd % 1024]));
        check(ret_data == exp_data[exp_rd % 1024], "R5/R6 return data",
              int'(ret_data), int'(exp_data[exp_rd % 1024]));
        exp_rd++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one issue slot; acceptance follows the full flag seen at the edge (R8)
  task automatic issue(input bit hit, input int t, output bit acc);
    iss_valid = 1'b1;
    iss_hit   = hit;
    iss_tag   = TAG_W'(t);
    iss_data  = hit ? hit_val(t) : DATA_W'(16'hDEAD);
    acc = (full === 1'b0);
    if (acc) begin
      exp_tag[exp_wr % 1024]  = TAG_W'(t);
      exp_data[exp_wr % 1024] = hit ? hit_val(t) : fill_val(t);
      exp_wr++;
    end
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic fill(input int t);
    fill_valid = 1'b1;
    fill_tag   = TAG_W'(t);
    fill_data  = fill_val(t);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 40 && exp_rd != exp_wr; k++) @(negedge clk);
    check(exp_rd == exp_wr, req, exp_rd, exp_wr);
  endtask

  initial begin
    bit acc;
    int mt [4];
    int nm, base, n0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ret_valid === 1'b0 && full === 1'b0, "R1 reset outputs", int'(ret_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ret_valid === 1'b0 && full === 1'b0, "R1 after reset", int'(full), 0);

    // R2: hit on empty queue comes back the next cycle
    issue(1'b1, 1, acc);
    check(ret_valid === 1'b1 && ret_tag == 4'd1 && ret_data == hit_val(1),
          "R2 bypass tag", int'(ret_tag), 1);
    @(negedge clk);

    // R3: four misses back to back all accepted
    for (int k = 0; k < 4; k++) begin
      issue(1'b0, 2 + k, acc);
      check(acc, "R3 miss accepted", int'(acc), 1);
    end
    check(full === 1'b1, "R8 full after DEPTH misses", int'(full), 1);
    n0 = nret;
    issue(1'b1, 6, acc);
    check(!acc && full === 1'b1, "R8 issue while full dropped", int'(acc), 0);
    fill(9);
    repeat (3) @(negedge clk);
    check(nret == n0 && full === 1'b1, "R6 unmatched fill no effect", nret, n0);
    fill(3);
    repeat (3) @(negedge clk);
    check(nret == n0, "R4 younger fill waits for head", nret, n0);
    fill(2);
    check(ret_valid === 1'b0, "R7 no return one cycle after fill", int'(ret_valid), 0);
    @(negedge clk);
    check(ret_valid === 1'b1 && ret_tag == 4'd2, "R7 head returns at t+2", int'(ret_tag), 2);
    check(full === 1'b0, "R8 full falls after retire", int'(full), 0);
    @(negedge clk);
    check(ret_valid === 1'b1 && ret_tag == 4'd3, "R7 next ready back to back", int'(ret_tag), 3);
    fill(5);
    fill(4);
    drain("R6 out-of-order fills drained");
    repeat (2) @(negedge clk);

    // sweep: every hit/miss pattern of four loads x four fill orders
    for (int mask = 0; mask < 16; mask++) begin
      for (int rot = 0; rot < 4; rot++) begin
        nm = 0;
        base = ntag;
        for (int k = 0; k < 4; k++) begin
          issue(mask[k], (base + k) % 16, acc);
          check(acc, "R3 sweep issue accepted", int'(acc), 1);
          if (!mask[k]) begin
            mt[nm] = (base + k) % 16;
            nm++;
          end
        end
        ntag = (base + 4) % 16;
        for (int k = 0; k < nm; k++) begin
          int j;
          case (rot)
            0:       j = k;
            1:       j = nm - 1 - k;
            2:       j = (k + 1) % nm;
            default: j = ((k ^ 1) < nm) ? (k ^ 1) : k;
          endcase
          fill(mt[j]);
        end
        drain("R4 sweep all returned");
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule